// File: doc/BRIEF.md
# Timer Square-Wave Clock Output

This block is a 16-bit timer set up as a clock source. A prescaler divides the system clock by a power of four chosen with a 3-bit code. Each prescaled tick advances an up-counter. When the counter equals the reload value, it wraps to zero, sets an overflow flag and flips a toggle stage. The toggle stage drives the output pin, so the output is a square wave with a 50% duty cycle. Its frequency is the prescaled clock divided by 2·(reload+1).

The mode runs only when both mode-select bits are 0 and the output enable is 1. In every other setting the counter holds at zero and the output stays low. The overflow flag still sets in this mode, but it never reaches the interrupt line.

A second input pin is watched for falling edges. This pin passes through a synchronizer, and its falling edges can set an external flag. That flag drives the interrupt when its own enable is set.

Top module: `clkout_timer`

## Requirements
- R1: The timer is active only when `mode_capture`=0, `mode_counter`=0 and `out_en`=1. While it is inactive, `clk_out` is 0 in the same cycle, `cnt_val` is 0 from the next clock onward, and the toggle stage resets to 0.
- R2: While the timer is active, each high or low phase of `clk_out` lasts exactly (reload+1)·P system clock cycles, where P is the prescale ratio. This gives a 50% duty cycle and a frequency of f_clk/(2·P·(reload+1)).
- R3: `ps_sel` values 0 to 5 give P = 4^ps_sel (1, 4, 16, 64, 256, 1024). Codes 6 and 7 give P = 1024.
- R4: With reload = 0, `clk_out` toggles on every prescaled tick.
- R5: A change to `reload` while the timer is active does not affect the half period in progress. It applies from the next counter wrap.
- R6: `updown_en` has no effect on the counter or on the output.
- R7: When the counter equals the latched reload value on a tick, `cnt_val` returns to 0, `ovf_flag` sets and `clk_out` toggles. `ovf_flag` stays set until an `ovf_clr` pulse clears it.
- R8: `ovf_flag` never asserts `irq`.
- R9: When `ext_en`=1, a falling edge on `ext_pin` sets `ext_flag`, with a latency of two synchronizer flops. A falling edge while `ext_en`=0 is ignored. `ext_clr` clears the flag.
- R10: `irq` equals `ext_flag` AND `ext_ie`.
- R11: After reset, `clk_out`, `cnt_val`, `ovf_flag`, `ext_flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_capture | input | 1 | Capture/reload select bit; must be 0 for this mode |
| mode_counter | input | 1 | Counter/timer select bit; must be 0 for this mode |
| out_en | input | 1 | Output enable |
| updown_en | input | 1 | Up/down count enable (ignored in this mode) |
| ps_sel | input | 3 | Prescaler code |
| reload | input | 16 | Reload value |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| ext_en | input | 1 | Enables falling-edge detection on `ext_pin` |
| ext_ie | input | 1 | Enables the interrupt from the external flag |
| ext_pin | input | 1 | Second input pin (asynchronous) |
| ext_clr | input | 1 | Clear strobe for the external flag |
| clk_out | output | 1 | Square-wave clock output |
| cnt_val | output | 16 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External falling-edge flag |
| irq | output | 1 | Timer interrupt |

## Verification
The main function is checked by measuring the length of each output phase for several reload and prescale pairs. Reload 4 with no division tells a correct compare from an off-by-one error. Reload 0 exposes faults where the output toggles every tick. Codes 1, 2, 6 and 7 with small reloads tell the 4^sel ratio apart from a linear or uncapped decode. A reload change made partway through a phase shows whether the new value is latched only at the wrap. Toggling the up/down bit, changing the mode bits and sending falling edges with different enable settings separate the overflow path from the interrupt path and the gated mode from the free-running one.

// File: rtl/clkout_timer.sv
module clkout_timer #(
  parameter int CNT_W   = 16,
  parameter int PS_W    = 3,
  parameter int MAX_SEL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_capture,
  input  logic             mode_counter,
  input  logic             out_en,
  input  logic             updown_en,
  input  logic [PS_W-1:0]  ps_sel,
  input  logic [CNT_W-1:0] reload,
  input  logic             ovf_clr,
  input  logic             ext_en,
  input  logic             ext_ie,
  input  logic             ext_pin,
  input  logic             ext_clr,
  output logic             clk_out,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             irq
);
  localparam int PRE_W = 2 * MAX_SEL;

  logic             active, tick, wrap, tog, fall;
  logic [PS_W-1:0]  sel_eff;
  logic [PRE_W:0]   mask_w;
  logic [PRE_W-1:0] pre_cnt, mask;
  logic [CNT_W-1:0] cnt, rel_q;
  logic [2:0]       sync;
  logic             unused_dir;

  assign unused_dir = updown_en;
  assign active  = !mode_capture && !mode_counter && out_en;
  assign sel_eff = (ps_sel > PS_W'(MAX_SEL)) ? PS_W'(MAX_SEL) : ps_sel;
  assign mask_w  = ((PRE_W+1)'(1) << (2 * sel_eff)) - (PRE_W+1)'(1);
  assign mask    = mask_w[PRE_W-1:0];
  assign tick    = active && ((pre_cnt & mask) == mask);
  assign wrap    = tick && (cnt == rel_q);
  assign fall    = sync[2] && !sync[1];

  assign clk_out = tog && active;
  assign cnt_val = cnt;
  assign irq     = ext_flag && ext_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
      rel_q   <= '0;
      tog     <= 1'b0;
    end else if (!active) begin
      pre_cnt <= '0;
      cnt     <= '0;
      rel_q   <= reload;
      tog     <= 1'b0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      if (wrap) begin
        cnt   <= '0;
        rel_q <= reload;
        tog   <= !tog;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= '1;
      ovf_flag <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      sync <= {sync[1:0], ext_pin};
      if (wrap)         ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (ext_en && fall) ext_flag <= 1'b1;
      else if (ext_clr)   ext_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/clkout_timer_chk.sv
module clkout_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_capture,
  input logic             mode_counter,
  input logic             out_en,
  input logic             ext_en,
  input logic             clk_out,
  input logic [CNT_W-1:0] cnt_val,
  input logic             ext_flag,
  input logic             irq
);
  logic on;
  assign on = !mode_capture && !mode_counter && out_en;

  p_low_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> !clk_out);

  p_cnt_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> cnt_val == '0);

  p_toggle_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (on && $past(on) && (clk_out != $past(clk_out))) |-> cnt_val == '0);

  p_no_overflow_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_flag |-> !irq);

  p_ext_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> $past(ext_en));
endmodule

bind clkout_timer clkout_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_capture(mode_capture),
  .mode_counter(mode_counter), .out_en(out_en), .ext_en(ext_en),
  .clk_out(clk_out), .cnt_val(cnt_val), .ext_flag(ext_flag), .irq(irq));

// File: tb/test_clkout_timer.sv
module test_clkout_timer;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        mode_capture = 0, mode_counter = 0, out_en = 0, updown_en = 0;
  logic [2:0]  ps_sel = 0;
  logic [15:0] reload = 0;
  logic        ovf_clr = 0, ext_en = 0, ext_ie = 0, ext_pin = 1, ext_clr = 0;
  logic        clk_out, ovf_flag, ext_flag, irq;
  logic [15:0] cnt_val;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = !clk;

  clkout_timer i_clkout_timer (
    .clk(clk), .rst_n(rst_n), .mode_capture(mode_capture),
    .mode_counter(mode_counter), .out_en(out_en), .updown_en(updown_en),
    .ps_sel(ps_sel), .reload(reload), .ovf_clr(ovf_clr), .ext_en(ext_en),
    .ext_ie(ext_ie), .ext_pin(ext_pin), .ext_clr(ext_clr),
    .clk_out(clk_out), .cnt_val(cnt_val), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .irq(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_next(output int n);
    logic v = clk_out;
    n = 0;
    while (clk_out == v && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure_half(output int n);
    int dummy;
    measure_next(dummy);
    measure_next(n);
  endtask

  task automatic setup(input logic [2:0] sel, input logic [15:0] rel);
    out_en = 0;
    repeat (2) @(negedge clk);
    ps_sel = sel;
    reload = rel;
    out_en = 1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(clk_out == 0 && cnt_val == 0 && ovf_flag == 0 && ext_flag == 0 && irq == 0,
          "R11 reset state", {clk_out, ovf_flag, ext_flag, irq}, 0);
  endtask

  task automatic t_ratio(input logic [2:0] sel, input logic [15:0] rel, input int exp, input string req);
    int n;
    setup(sel, rel);
    measure_half(n);
    check(n == exp, req, n, exp);
    measure_next(n);
    check(n == exp, {req, " second phase"}, n, exp);
  endtask

  task automatic t_updown;
    int n;
    updown_en = 1;
    setup(0, 4);
    measure_half(n);
    check(n == 5, "R6 updown_en ignored", n, 5);
    updown_en = 0;
  endtask

  task automatic t_reload_change;
    int n;
    setup(0, 9);
    measure_half(n);
    repeat (3) @(negedge clk);
    reload = 3;
    measure_next(n);
    check(n + 3 == 10, "R5 current phase keeps old reload", n + 3, 10);
    measure_next(n);
    check(n == 4, "R5 new reload after wrap", n, 4);
  endtask

  task automatic t_inactive;
    int n;
    setup(0, 20);
    measure_half(n);
    repeat (3) @(negedge clk);
    out_en = 0;
    #1;
    check(clk_out == 0, "R1 out_en low forces output low", clk_out, 0);
    repeat (3) @(negedge clk);
    check(cnt_val == 0 && clk_out == 0, "R1 counter held when disabled", cnt_val, 0);
    out_en = 1;
    mode_capture = 1;
    repeat (5) @(negedge clk);
    check(cnt_val == 0 && clk_out == 0, "R1 capture bit blocks mode", cnt_val, 0);
    mode_capture = 0;
    mode_counter = 1;
    repeat (5) @(negedge clk);
    check(cnt_val == 0 && clk_out == 0, "R1 counter bit blocks mode", cnt_val, 0);
    mode_counter = 0;
    repeat (3) @(negedge clk);
    check(clk_out == 0 && cnt_val == 3, "R1 restart from zero with toggle reset", cnt_val, 3);
  endtask

  task automatic t_overflow;
    int n;
    ext_en = 0;
    ext_ie = 1;
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    setup(0, 4);
    measure_half(n);
    check(cnt_val == 0, "R7 counter wraps to zero at toggle", cnt_val, 0);
    check(ovf_flag == 1, "R7 overflow flag set", ovf_flag, 1);
    check(irq == 0, "R8 overflow raises no irq", irq, 0);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    check(ovf_flag == 0, "R7 ovf_clr clears flag", ovf_flag, 1'b0);
    ext_ie = 0;
  endtask

  task automatic t_external;
    ext_en = 1;
    ext_ie = 0;
    ext_pin = 0;
    repeat (2) @(negedge clk);
    check(ext_flag == 0, "R9 two-flop latency", ext_flag, 0);
    @(negedge clk);
    check(ext_flag == 1, "R9 falling edge sets flag", ext_flag, 1);
    check(irq == 0, "R10 irq needs ext_ie", irq, 0);
    ext_ie = 1;
    #1;
    check(irq == 1, "R10 irq follows flag and enable", irq, 1);
    ext_clr = 1;
    @(negedge clk);
    ext_clr = 0;
    check(ext_flag == 0 && irq == 0, "R9 ext_clr clears flag", ext_flag, 0);
    ext_en = 0;
    ext_pin = 1;
    repeat (4) @(negedge clk);
    ext_pin = 0;
    repeat (6) @(negedge clk);
    check(ext_flag == 0, "R9 edge ignored when ext_en low", ext_flag, 0);
    ext_pin = 1;
    ext_ie = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ratio(0, 4, 5, "R2 reload 4 divide 1");
    t_ratio(1, 2, 12, "R3 code 1 divide 4");
    t_ratio(2, 0, 16, "R3 code 2 divide 16");
    t_ratio(6, 0, 1024, "R3 code 6 caps at 1024");
    t_ratio(7, 1, 2048, "R3 code 7 caps at 1024");
    t_ratio(0, 0, 1, "R4 reload zero toggles each tick");
    t_updown();
    t_reload_change();
    t_inactive();
    t_overflow();
    t_external();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule